// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins. The pins are grouped into 32-pin register sets. Each set holds a pin direction word, an output latch, a synchronised view of the pin levels, rising and falling edge enables, and an interrupt status word. A host reaches all of it through a single-cycle register bus. Reads are combinational in the same cycle, and a write takes effect at the clock edge that samples it.

Every control field except direction is changed through paired write-one-to-set and write-one-to-clear words. The host can therefore change individual pins without a read-modify-write. The status word is cleared by writing ones.

Interrupts are grouped in 16-pin banks, two banks per register set. Each bank drives one level output. That output is high while any of the bank's status bits is set and the bank's bit in a shared bank-enable word is 1.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Reset has these effects:
  - The direction word of every set becomes all ones, so every pin is an input and `pin_oe` is all zeros.
  - The output latch, both edge-enable words, the status word and the bank-enable word become zero.
  - Every `bank_irq` line is low.
- R2: The direction word is at set offset 0x00 and is written directly.
  - A direction bit of 1 makes the pin an input: its `pin_oe` bit is 0.
  - A direction bit of 0 makes the pin an output: its `pin_oe` bit is 1.
  - `pin_out` always carries the output latch.
- R3: Writing to the set-data word (offset 0x08) sets the latch bits written as 1. Writing to the clear-data word (offset 0x0C) clears the latch bits written as 1. Bits written as 0 leave the latch unchanged. Offsets 0x04, 0x08 and 0x0C all read back the latch. A write to offset 0x04 is ignored.
- R4: The input word at offset 0x10 reads the pin level after a two-flop synchroniser. This holds whatever the pin's direction is. A pin change driven before clock edge E1 reads back from just after edge E2, not before. Writes to this word are ignored.
- R5: The rising-edge enable is set by writing ones to offset 0x14 and cleared by writing ones to offset 0x18. The falling-edge enable is set by writing ones to offset 0x1C and cleared by writing ones to offset 0x20. Both offsets of a pair read back the current enable word.
- R6: A pin transition sets the pin's status bit when the enable for that direction of edge is 1. The bit is set at the third clock edge after the pin changes. Both edge enables may be active on one pin at once. A transition whose enable is 0 sets nothing.
- R7: The status word at offset 0x24 is cleared by writing ones to it. Zero bits have no effect. If a new edge and a clear of the same bit arrive in the same cycle, the bit stays set.
- R8: Bank interrupts work as follows:
  - Bank 2k takes status bits 15:0 of set k. Bank 2k+1 takes bits 31:16 of set k.
  - `bank_irq[b]` is the OR of the bank's 16 status bits, ANDed with bit b of the bank-enable word.
  - The bank-enable word is at byte address 0x08. It is written directly and has unused bits that read as 0.
- R9: Set k is based at byte address 0x10 + 0x28·k. Reads of any other address, of an address that is not word-aligned, or with `bus_sel` low return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (qualified by bus_sel) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pin_out | output | NUM_PINS | Output latch value |
| pin_oe | output | NUM_PINS | Output enable, 1 = drive |
| bank_irq | output | NUM_BANKS | Per-bank interrupt level |

## Verification
Register writes show on `pin_out`, `pin_oe` and on reads at the clock edge that samples them. The bench therefore reads back in the low phase after that edge.

The input word follows a pin change after exactly two edges. Status bits and `bank_irq` follow it after three edges. Directed checks sample at the phase just before and just after each of these edges. The bench also presents a status clear in the very cycle the third edge sets the bit.

Random pin steps wait four edges before comparing against the bench's model. After every operation, every address is read back, with no clock advancing between the read setup and the sample.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and the register index type of the banked GPIO block.
// Assumes a byte-addressed bus with 32-bit words.
package gpio_bank_pkg;
    localparam int WORD_W       = 32;
    localparam int SET_PINS     = 32;
    localparam int BANK_PINS    = 16;
    localparam int MAX_PINS     = 144;
    localparam int REGS_PER_SET = 10;
    localparam int SET_BASE     = 'h10;
    localparam int SET_STRIDE   = 'h28;
    localparam int BANK_EN_ADDR = 'h08;

    // Word index inside one register set; the order fixes the offsets.
    typedef enum logic [3:0] {
        RIX_DIR  = 4'd0,
        RIX_OUT  = 4'd1,
        RIX_SETD = 4'd2,
        RIX_CLRD = 4'd3,
        RIX_IN   = 4'd4,
        RIX_SETR = 4'd5,
        RIX_CLRR = 4'd6,
        RIX_SETF = 4'd7,
        RIX_CLRF = 4'd8,
        RIX_STAT = 4'd9
    } reg_idx_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is given.
module gpio_pin_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages that bring the pad levels into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            dout   <= '0;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_regset.sv
// One 32-pin register set: direction, output latch, edge enables,
// edge detection and write-one-to-clear status. Assumes pin_sync is
// already synchronised and wr_en is only high for an in-range word.
module gpio_regset
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_idx_e    idx,
    input  logic [31:0] wdata,
    input  logic [31:0] pin_sync,
    output logic [31:0] rdata,
    output logic [31:0] dir_q,
    output logic [31:0] out_q,
    output logic [31:0] stat_q,
    output logic [1:0]  half_any
);
    logic [31:0] rise_q;
    logic [31:0] fall_q;
    logic [31:0] prev_q;
    logic [31:0] edge_hit;
    logic [31:0] clr_mask;

    assign edge_hit = (pin_sync & ~prev_q & rise_q) | (~pin_sync & prev_q & fall_q);
    assign clr_mask = (wr_en && idx == RIX_STAT) ? wdata : '0;
    assign half_any = {|stat_q[31:16], |stat_q[15:0]};

    // Direction word, written whole; reset makes every pin an input.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= '1;
        else if (wr_en && idx == RIX_DIR)    dir_q <= wdata;
    end

    // Output latch, changed only through the set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n)                          out_q <= '0;
        else if (wr_en && idx == RIX_SETD)   out_q <= out_q | wdata;
        else if (wr_en && idx == RIX_CLRD)   out_q <= out_q & ~wdata;
    end

    // Rising-edge enables through their set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rise_q <= '0;
        else if (wr_en && idx == RIX_SETR)   rise_q <= rise_q | wdata;
        else if (wr_en && idx == RIX_CLRR)   rise_q <= rise_q & ~wdata;
    end

    // Falling-edge enables through their set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fall_q <= '0;
        else if (wr_en && idx == RIX_SETF)   fall_q <= fall_q | wdata;
        else if (wr_en && idx == RIX_CLRF)   fall_q <= fall_q & ~wdata;
    end

    // Previous synchronised level, the reference for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    // Status: a new edge wins over a simultaneous write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | edge_hit;
    end

    // Read selection for the addressed word.
    always_comb begin
        unique case (idx)
            RIX_DIR:                      rdata = dir_q;
            RIX_OUT, RIX_SETD, RIX_CLRD:  rdata = out_q;
            RIX_IN:                       rdata = pin_sync;
            RIX_SETR, RIX_CLRR:           rdata = rise_q;
            RIX_SETF, RIX_CLRF:           rdata = fall_q;
            RIX_STAT:                     rdata = stat_q;
            default:                      rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_banked_ctrl.sv
// Top of the banked GPIO controller: address decode, read mux,
// synchroniser, register sets and gated per-bank interrupt levels.
// Assumes NUM_PINS in 1..144 and ADDR_W wide enough for the last set.
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int  NUM_PINS  = 64,
    parameter int  ADDR_W    = 8,
    localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe,
    output logic [NUM_BANKS-1:0] bank_irq
);
    localparam int NUM_SETS = (NUM_PINS + SET_PINS - 1) / SET_PINS;
    localparam int PAD_PINS = NUM_SETS * SET_PINS;

    logic [PAD_PINS-1:0]   pin_pad;
    logic [PAD_PINS-1:0]   pin_sync;
    logic [PAD_PINS-1:0]   dir_all;
    logic [PAD_PINS-1:0]   out_all;
    logic [PAD_PINS-1:0]   stat_all;
    logic [2*NUM_SETS-1:0] half_flat;
    logic [NUM_SETS-1:0]   set_hit;
    logic [31:0]           set_rd [NUM_SETS];
    logic [NUM_BANKS-1:0]  ben;
    logic                  ben_hit;
    logic                  bus_we;

    assign pin_pad = PAD_PINS'(pin_in);
    assign bus_we  = bus_sel && bus_wr;
    assign ben_hit = (bus_addr == ADDR_W'(BANK_EN_ADDR));

    gpio_pin_sync #(.WIDTH(PAD_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_pad),
        .dout (pin_sync)
    );

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        localparam int BASE = SET_BASE + k * SET_STRIDE;
        logic [ADDR_W-1:0] offs;
        reg_idx_e          set_idx;

        assign offs       = bus_addr - ADDR_W'(BASE);
        assign set_hit[k] = (bus_addr >= ADDR_W'(BASE))
                         && (offs < ADDR_W'(REGS_PER_SET * 4))
                         && (offs[1:0] == 2'b00);
        assign set_idx    = reg_idx_e'(offs[5:2]);

        gpio_regset u_regset (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && set_hit[k]),
            .idx     (set_idx),
            .wdata   (bus_wdata),
            .pin_sync(pin_sync[k*SET_PINS +: SET_PINS]),
            .rdata   (set_rd[k]),
            .dir_q   (dir_all[k*SET_PINS +: SET_PINS]),
            .out_q   (out_all[k*SET_PINS +: SET_PINS]),
            .stat_q  (stat_all[k*SET_PINS +: SET_PINS]),
            .half_any(half_flat[2*k +: 2])
        );
    end

    // Bank enable word, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)               ben <= '0;
        else if (bus_we && ben_hit) ben <= bus_wdata[NUM_BANKS-1:0];
    end

    // Read mux: zero unless a mapped, aligned word is addressed.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (ben_hit) bus_rdata = 32'(ben);
            for (int k = 0; k < NUM_SETS; k++) begin
                if (set_hit[k]) bus_rdata = set_rd[k];
            end
        end
    end

    // Bank b maps to half (b mod 2) of set b/2, gated by its enable.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_irq[b] = ben[b] & half_flat[b];
    end

    assign pin_out = out_all[NUM_PINS-1:0];
    assign pin_oe  = ~dir_all[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
// Property checker for gpio_banked_ctrl, attached by bind below.
// Observes the ports and the flattened register vectors of the top.
module gpio_banked_ctrl_chk #(
    parameter int NUM_PINS = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [31:0]          bus_rdata,
    input logic [((NUM_PINS+31)/32)*32-1:0] dir_all,
    input logic [((NUM_PINS+31)/32)*32-1:0] out_all,
    input logic [((NUM_PINS+31)/32)*32-1:0] stat_all,
    input logic [(NUM_PINS+15)/16-1:0]      ben,
    input logic [(NUM_PINS+15)/16-1:0]      bank_irq
);
    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(dir_all));

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(out_all));

    assert_stat_no_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ((~stat_all & $past(stat_all)) == '0));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq & ~ben) == '0);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq != '0) |-> (stat_all != '0));

    assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .dir_all  (dir_all),
    .out_all  (out_all),
    .stat_all (stat_all),
    .ben      (ben),
    .bank_irq (bank_irq)
);

// File: tb/tb_gpio_banked_ctrl.sv
module tb_gpio_banked_ctrl;
    localparam int NP = 64;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NB-1:0] bank_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_dir [2];
    logic [31:0] m_out [2];
    logic [31:0] m_rise[2];
    logic [31:0] m_fall[2];
    logic [31:0] m_stat[2];
    logic [3:0]  m_ben;
    logic [63:0] m_pins;

    gpio_banked_ctrl #(.NUM_PINS(NP), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Decode an address into set number and word index; -1 when unmapped.
    function automatic int word_of(input logic [7:0] a, output int s);
        s = 0;
        for (int k = 0; k < 2; k++) begin
            int base = 16 + 40 * k;
            if (int'(a) >= base && int'(a) < base + 40 && a[1:0] == 2'b00) begin
                s = k;
                return (int'(a) - base) / 4;
            end
        end
        return -1;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int s;
        int w = word_of(a, s);
        if (a == 8'h08) return {28'b0, m_ben};
        case (w)
            0:       return m_dir[s];
            1, 2, 3: return m_out[s];
            4:       return m_pins[32*s +: 32];
            5, 6:    return m_rise[s];
            7, 8:    return m_fall[s];
            9:       return m_stat[s];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        int s;
        int w = word_of(a, s);
        if (a == 8'h08) return "R8";
        case (w)
            0:          return "R2";
            1, 2, 3:    return "R3";
            4:          return "R4";
            5, 6, 7, 8: return "R5";
            9:          return "R7";
            default:    return "R9";
        endcase
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
        int s;
        int w = word_of(a, s);
        if (a == 8'h08) m_ben = d[3:0];
        case (w)
            0: m_dir[s]  = d;
            2: m_out[s]  = m_out[s] | d;
            3: m_out[s]  = m_out[s] & ~d;
            5: m_rise[s] = m_rise[s] | d;
            6: m_rise[s] = m_rise[s] & ~d;
            7: m_fall[s] = m_fall[s] | d;
            8: m_fall[s] = m_fall[s] & ~d;
            9: m_stat[s] = m_stat[s] & ~d;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Change pins, let synchroniser and detector settle, update the model.
    task automatic pin_step(input logic [63:0] nv);
        logic [63:0] up, dn, en_r, en_f;
        @(negedge clk);
        bus_sel = 1'b0;
        pin_in = nv;
        repeat (4) @(posedge clk);
        up   = ~m_pins & nv;
        dn   = m_pins & ~nv;
        en_r = {m_rise[1], m_rise[0]};
        en_f = {m_fall[1], m_fall[0]};
        {m_stat[1], m_stat[0]} = {m_stat[1], m_stat[0]} | (up & en_r) | (dn & en_f);
        m_pins = nv;
    endtask

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int b = 0; b < 4; b++)
            r[b] = m_ben[b] & (|m_stat[b/2][16*(b%2) +: 16]);
        return r;
    endfunction

    task automatic check_all();
        logic [31:0] d;
        logic [7:0]  odd [4] = '{8'h00, 8'h0C, 8'hE0, 8'h11};
        rd(8'h08, d); chk("R8", "bank enable", 64'(d), 64'(exp_rd(8'h08)));
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 10; i++) begin
                logic [7:0] a = 8'(16 + 40 * s + 4 * i);
                rd(a, d);
                chk(tag_of(a), $sformatf("read %h", a), 64'(d), 64'(exp_rd(a)));
            end
        end
        for (int i = 0; i < 4; i++) begin
            rd(odd[i], d);
            chk("R9", $sformatf("unmapped %h", odd[i]), 64'(d), 64'h0);
        end
        bus_sel = 1'b0;
        #1;
        chk("R9", "idle read", 64'(bus_rdata), 64'h0);
        chk("R3", "pin_out", pin_out, {m_out[1], m_out[0]});
        chk("R2", "pin_oe", pin_oe, ~{m_dir[1], m_dir[0]});
        chk("R8", "bank_irq", 64'(bank_irq), 64'(exp_irq()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int s = 0; s < 2; s++) begin
            m_dir[s] = '1; m_out[s] = '0; m_rise[s] = '0; m_fall[s] = '0; m_stat[s] = '0;
        end
        m_ben = '0; m_pins = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1", "pin_oe after reset", pin_oe, 64'h0);
        chk("R1", "bank_irq after reset", 64'(bank_irq), 64'h0);
        rd(8'h10, d); chk("R1", "dir after reset", 64'(d), 64'hFFFF_FFFF);
        rd(8'h5C, d); chk("R1", "status after reset", 64'(d), 64'h0);
        check_all();

        // R3: set/clear only touch ones; direct latch write ignored
        wr(8'h18, 32'h0000_00F0);
        wr(8'h1C, 32'h0000_0030);
        wr(8'h14, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R3", "latch after set/clear", pin_out, 64'h0000_0000_0000_00C0);
        // R2: output enable follows direction zeros
        wr(8'h38, 32'hFFFF_FFFE);
        @(negedge clk);
        chk("R2", "oe of pin 32", pin_oe, 64'h0000_0001_0000_0000);
        check_all();

        // R4: synchroniser latency of two edges
        @(negedge clk);
        pin_in = m_pins ^ 64'h8;
        @(posedge clk);
        rd(8'h20, d); chk("R4", "input after one edge", 64'(d), 64'(m_pins[31:0]));
        @(posedge clk);
        rd(8'h20, d); chk("R4", "input after two edges", 64'(d), 64'(m_pins[31:0] ^ 32'h8));
        bus_sel = 1'b0;
        repeat (3) @(posedge clk);
        m_pins = m_pins ^ 64'h8;
        wr(8'h20, 32'h0);
        check_all();

        // R6/R8: rising edge on pin 37 sets status on the third edge
        wr(8'h4C, 32'h20);
        @(negedge clk);
        pin_in[37] = 1'b1;
        @(posedge clk); @(posedge clk);
        rd(8'h5C, d); chk("R6", "status before third edge", 64'(d), 64'h0);
        @(posedge clk);
        rd(8'h5C, d); chk("R6", "status after third edge", 64'(d), 64'h20);
        bus_sel = 1'b0;
        m_pins[37] = 1'b1; m_stat[1] = 32'h20;
        #1 chk("R8", "irq masked by bank enable", 64'(bank_irq), 64'h0);
        wr(8'h08, 32'h4);
        #1 chk("R8", "bank 2 irq", 64'(bank_irq), 64'h4);
        wr(8'h5C, 32'h0);
        rd(8'h5C, d); chk("R7", "zero write keeps status", 64'(d), 64'h20);
        wr(8'h5C, 32'h20);
        #1 chk("R7", "irq after clear", 64'(bank_irq), 64'h0);
        // R6: both edges on one pin; a disabled edge sets nothing
        wr(8'h54, 32'h20);
        pin_step(m_pins & ~(64'h1 << 37));
        rd(8'h5C, d); chk("R6", "falling edge", 64'(d), 64'h20);
        wr(8'h5C, 32'h20);
        pin_step(m_pins | (64'h1 << 37));
        rd(8'h5C, d); chk("R6", "rising edge", 64'(d), 64'h20);
        wr(8'h5C, 32'h20);
        pin_step(m_pins | (64'h1 << 38));
        rd(8'h5C, d); chk("R6", "disabled edge", 64'(d), 64'h0);
        check_all();

        // R7: edge and clear in the same cycle, set wins
        wr(8'h24, 32'h1);
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h1;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
        m_pins[0] = 1'b1; m_stat[0] = m_stat[0] | 32'h1;
        rd(8'h34, d); chk("R7", "set beats clear", 64'(d & 32'h1), 64'h1);
        check_all();

        // Random mix of writes, pin steps and unmapped writes
        for (int it = 0; it < 250; it++) begin
            int op = int'($urandom % 8);
            logic [31:0] dat = $urandom;
            if ($urandom % 3 == 0) dat = dat & $urandom & $urandom;
            if (op <= 4) begin
                if ($urandom % 8 == 0) wr(8'h08, dat);
                else wr(8'(16 + 40 * ($urandom % 2) + 4 * ($urandom % 10)), dat);
            end else if (op <= 6) begin
                pin_step(m_pins ^ {$urandom & $urandom, $urandom & $urandom});
            end else begin
                logic [7:0] bad [4] = '{8'h00, 8'h04, 8'hE4, 8'h1A};
                wr(bad[$urandom % 4], dat);
            end
            check_all();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule